// File: doc/BRIEF.md
# Write Strobe Protection Qualifier

This block sits between the pins of a flash-style memory and its command decoder. It decides whether a bus write attempt may reach the decoder. It watches the sampled active-low chip-enable, write-enable and output-enable pins together with a digital supply-good indication. It passes on only those writes that survive three screens: a minimum-width filter on the joint low time of the two strobes, a lockout timer that keeps writes off for a fixed number of cycles after supply-good rises, and pin-state inhibit rules.

A write window is the run of clock samples on which chip-enable and write-enable are both low. The window therefore opens on whichever strobe falls last and closes on whichever strobe rises first. The address is captured on the first sample of the window. The data is captured on the sample where the window is first seen closed. An accepted write produces a single-cycle pulse on `wr_pulse`. The captured address and data appear on `wr_addr` and `wr_data` in the same cycle. Both hold their values until the next accepted write. All pins are assumed to be synchronous to `clk` already, and the filter width and lockout delay are parameters counted in clock cycles.

Top module: `wstrobe_qualifier`

## Requirements
- R1: A window of at least `MIN_LOW_CYC` samples that passes every screen makes `wr_pulse` high for exactly one cycle, just after the clock edge that samples the window closing (either strobe high).
- R2: A window shorter than `MIN_LOW_CYC` samples never produces a pulse.
- R3: If output-enable is low on any sample of the window, the write is inhibited.
- R4: If supply-good is low on any sample of the window, or on the closing sample, the write is inhibited.
- R5: A window sample counts as permitted only when supply-good is high on it and on at least `POR_DELAY_CYC` consecutive samples before it. A window with any sample that is not permitted is dropped.
- R6: When supply-good falls, the lockout count clears. After supply-good rises again, the full `POR_DELAY_CYC` delay must elapse before a write is accepted.
- R7: On an accepted write, `wr_addr` equals the address present on the first sample of the window, which is the later of the two falling strobes.
- R8: On an accepted write, `wr_data` equals the data present on the sample where the window is first seen closed, which is the first rising strobe.
- R9: While reset is asserted, `wr_pulse`, `wr_addr` and `wr_data` are zero and the lockout count is cleared.
- R10: `wr_addr` and `wr_data` change only in a cycle in which `wr_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Sampled chip enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| pwr_good | input | 1 | Supply-above-threshold indication |
| addr | input | ADDR_W | Address bus |
| data | input | DATA_W | Data bus |
| wr_pulse | output | 1 | Single-cycle qualified write strobe |
| wr_addr | output | ADDR_W | Address latched for the qualified write |
| wr_data | output | DATA_W | Data latched for the qualified write |

## Verification
The hardest case to reach is a supply drop in the middle of a write window, followed by a write that arrives while the restarted lockout is still counting down. From the ports, that takes a supply glitch placed at the right sample and a second transaction timed inside the fresh delay. The stimulus drops supply-good at a random sample inside about one window in thirty, then keeps issuing writes with short gaps so that several of them land inside the new lockout. Directed sequences add a write that opens exactly one sample before the lockout expires, windows exactly one sample short of and exactly at the filter width, and windows with the two strobes falling and rising in either order.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  // Write-window tracking phase
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_phase_e;

  // Saturating increment helper for small counters
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/wsq_rst_sync.sv
module wsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wsq_por_timer.sv
module wsq_por_timer #(
  parameter int DELAY_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ready
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!pwr_good)            cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == CNT_MAX);
endmodule

// File: rtl/wsq_strobe_window.sv
module wsq_strobe_window
  import wsq_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 16,
  parameter int MIN_LOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              allow,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] LEN_MAX = LW'(MIN_LOW_CYC);

  win_phase_e        phase_q, phase_d;
  logic [LW-1:0]     len_q, len_d;
  logic              ok_q, ok_d;
  logic [ADDR_W-1:0] alat_q, alat_d;
  logic              pulse_q, pulse_d;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  logic joint_low, win_start, win_stop, sample_ok, wide_enough;

  assign joint_low = ~ce_n & ~we_n;
  assign win_start = joint_low & (phase_q == WIN_IDLE);
  assign win_stop  = ~joint_low & (phase_q == WIN_OPEN);
  assign sample_ok = oe_n & allow;

  generate
    if (MIN_LOW_CYC <= 1) begin : g_no_filter
      assign wide_enough = 1'b1;
    end else begin : g_filter
      assign wide_enough = (len_q == LEN_MAX);
    end
  endgenerate

  // Next-state logic
  always_comb begin
    phase_d = joint_low ? WIN_OPEN : WIN_IDLE;
    len_d   = len_q;
    ok_d    = ok_q;
    alat_d  = alat_q;
    if (win_start) begin
      len_d  = LW'(1);
      ok_d   = sample_ok;
      alat_d = addr;
    end else if (joint_low) begin
      if (len_q != LEN_MAX) len_d = len_q + 1'b1;
      ok_d = ok_q & sample_ok;
    end
    pulse_d = win_stop & ok_q & wide_enough & allow;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WIN_IDLE;
      len_q   <= '0;
      ok_q    <= 1'b0;
      alat_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      len_q   <= len_d;
      ok_q    <= ok_d;
      pulse_q <= pulse_d;
      if (win_start) alat_q <= alat_d;
    end
  end

  // Output capture registers, enabled only by an accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (pulse_d) begin
      waddr_q <= alat_q;
      wdata_q <= data;
    end
  end

  assign wr_pulse = pulse_q;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;
endmodule

// File: rtl/wstrobe_qualifier.sv
module wstrobe_qualifier #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int MIN_LOW_CYC   = 2,
  parameter int POR_DELAY_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic rst_int_n;
  logic por_ready;
  logic write_allow;

  wsq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  wsq_por_timer #(.DELAY_CYC(POR_DELAY_CYC)) u_por_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pwr_good (pwr_good),
    .ready    (por_ready)
  );

  assign write_allow = pwr_good & por_ready;

  wsq_strobe_window #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MIN_LOW_CYC (MIN_LOW_CYC)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .allow    (write_allow),
    .addr     (addr),
    .data     (data),
    .wr_pulse (wr_pulse),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int MIN_LOW_CYC   = 2,
  parameter int POR_DELAY_CYC = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              pwr_good,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              wr_pulse,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int RUN_LIM = POR_DELAY_CYC + 2;
  localparam int RW = $clog2(RUN_LIM + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LIM);
  localparam int JW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [JW-1:0] JL_MAX = JW'(MIN_LOW_CYC);

  logic [RW-1:0] run_q;
  logic [JW-1:0] jl_q;
  logic          act_q;
  logic          act_now;

  assign act_now = ~ce_n & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      jl_q  <= '0;
      act_q <= 1'b0;
    end else begin
      if (!pwr_good)            run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (!act_now)             jl_q <= '0;
      else if (jl_q != JL_MAX)  jl_q <= jl_q + 1'b1;
      act_q <= act_now;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R1
  AST_PULSE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> ($past(ce_n | we_n) && $past(~ce_n & ~we_n, 2))); // R1
  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !act_now && (jl_q < JL_MAX)) |=> !wr_pulse); // R2
  AST_PULSE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(oe_n, 2)); // R3
  AST_PULSE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !wr_pulse); // R4
  AST_PULSE_AFTER_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> (run_q == RUN_MAX)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data))); // R10
endmodule

bind wstrobe_qualifier wsq_checker #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .MIN_LOW_CYC   (MIN_LOW_CYC),
  .POR_DELAY_CYC (POR_DELAY_CYC)
) u_wsq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .pwr_good (pwr_good),
  .addr     (addr),
  .data     (data),
  .wr_pulse (wr_pulse),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/wstrobe_qualifier_tb_top.sv
module wstrobe_qualifier_tb_top;
  localparam int AW    = 17;
  localparam int DW    = 16;
  localparam int MINL  = 3;
  localparam int DELAY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_good = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          wr_pulse;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wstrobe_qualifier #(
    .ADDR_W(AW), .DATA_W(DW), .MIN_LOW_CYC(MINL), .POR_DELAY_CYC(DELAY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_good(pwr_good), .addr(addr), .data(data),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Reference model state, built from the requirements
  int            run = 0;
  bit            had_drop = 1'b0;
  bit            m_act = 1'b0;
  int            m_len = 0;
  bit            m_ok = 1'b0;
  string         m_why = "R1";
  logic [AW-1:0] m_addr = '0;
  bit            exp_pulse = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  string         exp_tag = "R1";
  bit            cur_pg = 1'b0;
  int            accepted = 0;

  function automatic string block_reason(bit oe, bit pg);
    if (!oe) return "R3";
    if (!pg) return "R4";
    return had_drop ? "R6" : "R5";
  endfunction

  function automatic void model(bit ce, bit we, bit oe, bit pg,
                                logic [AW-1:0] a, logic [DW-1:0] d);
    bit act, allow, start, stop;
    act   = !ce && !we;
    allow = pg && (run >= DELAY);
    start = act && !m_act;
    stop  = !act && m_act;
    exp_pulse = 1'b0;
    exp_tag   = "R1";
    if (stop) begin
      if (!pg)                exp_tag = "R4";
      else if (run < DELAY)   exp_tag = had_drop ? "R6" : "R5";
      else if (m_len < MINL)  exp_tag = "R2";
      else if (!m_ok)         exp_tag = m_why;
      else begin
        exp_pulse = 1'b1;
        exp_addr  = m_addr;
        exp_data  = d;
      end
    end
    if (start) begin
      m_len = 1;
      m_ok  = oe && allow;
      m_why = block_reason(oe, pg);
      m_addr = a;
    end else if (act) begin
      m_len++;
      if (m_ok && !(oe && allow)) begin
        m_ok  = 1'b0;
        m_why = block_reason(oe, pg);
      end
    end
    m_act = act;
    if (!pg) begin
      if (run > 0) had_drop = 1'b1;
      run = 0;
    end else if (run < DELAY) run++;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit ce, bit we, bit oe, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    chk(exp_tag, "wr_pulse", 32'(wr_pulse), 32'(exp_pulse));
    chk(exp_pulse ? "R7" : "R10", "wr_addr", 32'(wr_addr), 32'(exp_addr));
    chk(exp_pulse ? "R8" : "R10", "wr_data", 32'(wr_data), 32'(exp_data));
    if (exp_pulse) accepted++;
    ce_n = ce; we_n = we; oe_n = oe; pwr_good = cur_pg; addr = a; data = d;
    model(ce, we, oe, cur_pg, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b1, AW'($urandom()), DW'($urandom()));
  endtask

  // One write: lead strobe, len joint-low samples, trailing strobe, release
  task automatic write_txn(logic [AW-1:0] a, logic [DW-1:0] d, int len,
                           int oe_idx, int drop_idx, bit ce_first, bit we_rises_first);
    step(ce_first ? 1'b0 : 1'b1, ce_first ? 1'b1 : 1'b0, 1'b1,
         AW'($urandom()), DW'($urandom()));
    for (int i = 0; i < len; i++) begin
      if (i == drop_idx) cur_pg = 1'b0;
      step(1'b0, 1'b0, (i == oe_idx) ? 1'b0 : 1'b1,
           (i == 0) ? a : AW'($urandom()), DW'($urandom()));
    end
    step(we_rises_first ? 1'b0 : 1'b1, we_rises_first ? 1'b1 : 1'b0, 1'b1,
         AW'($urandom()), d);
    step(1'b1, 1'b1, 1'b1, AW'($urandom()), DW'($urandom()));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    int n_ok;
    void'($urandom(32'd7321));
    // R9: outputs cleared while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "wr_pulse in reset", 32'(wr_pulse), 32'd0);
    chk("R9", "wr_addr in reset", 32'(wr_addr), 32'd0);
    chk("R9", "wr_data in reset", 32'(wr_data), 32'd0);
    rst_n = 1'b1;
    idle(5);

    // R5: supply up, write attempted before the lockout ends
    cur_pg = 1'b1;
    idle(4);
    write_txn(17'h00123, 16'hBEEF, 4, -1, -1, 1'b1, 1'b1);
    // R5 boundary: window opens one sample before lockout end (run==DELAY-1)
    idle(DELAY - 1 - run - 1);
    write_txn(17'h00456, 16'h1234, 4, -1, -1, 1'b1, 1'b1);
    idle(3);
    // R1/R7/R8: accepted write, both strobe orders
    n_ok = accepted;
    write_txn(17'h1F001, 16'hA5A5, 4, -1, -1, 1'b1, 1'b1);
    write_txn(17'h03F00, 16'h5A5A, 3, -1, -1, 1'b0, 1'b0);
    idle(1);
    chk("R1", "accepted directed writes", 32'(accepted - n_ok), 32'd2);
    // R2: one sample short of the filter, then exactly at it
    write_txn(17'h05000, 16'h0F0F, MINL - 1, -1, -1, 1'b1, 1'b0);
    write_txn(17'h05001, 16'hF0F0, MINL, -1, -1, 1'b0, 1'b1);
    write_txn(17'h05002, 16'h0001, 1, -1, -1, 1'b1, 1'b1);
    // R3: output enable low inside the window
    write_txn(17'h00777, 16'h7777, 5, 2, -1, 1'b1, 1'b1);
    // R4 then R6: supply dropped mid window, restored, lockout restarts
    write_txn(17'h00888, 16'h8888, 5, -1, 3, 1'b1, 1'b1);
    idle(2);
    cur_pg = 1'b1;
    idle(DELAY / 2);
    write_txn(17'h00999, 16'h9999, 4, -1, -1, 1'b1, 1'b1);
    idle(DELAY);
    n_ok = accepted;
    write_txn(17'h00AAA, 16'hAAAA, 4, -1, -1, 1'b0, 1'b1);
    idle(1);
    chk("R6", "write after restarted lockout", 32'(accepted - n_ok), 32'd1);

    // Random mix
    for (int t = 0; t < 300; t++) begin
      int len, oe_idx, drop_idx;
      if (!cur_pg) cur_pg = 1'b1;
      idle($urandom_range(0, 2));
      len      = $urandom_range(1, 6);
      oe_idx   = ($urandom_range(0, 9) == 0) ? $urandom_range(0, len - 1) : -1;
      drop_idx = ($urandom_range(0, 29) == 0) ? $urandom_range(0, len - 1) : -1;
      write_txn(AW'($urandom()), DW'($urandom()), len, oe_idx, drop_idx,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule